// File: doc/BRIEF.md
# Strand Dispatch Engine

This block sits in the front end between instruction decode and register rename. It receives one decoded instruction per cycle and sends the program counter to a small strand store. A strand is a short chain of two or three dependent ALU instructions. The store holds the chain's member PCs, the destination register and result of each member, and the older value of the chain's final destination. When the head of a strand that the store marks ready arrives, the engine emits one precomputed strand operation in its place. It then deletes the remaining members from the stream as they arrive.

The strand skips the writes to its intermediate registers, so those registers hold stale values. A dirty table marks them and keeps the value each should hold. When a later instruction reads a dirty register, the engine first emits a recovery write that restores the register, and the reader follows. The strand also writes its final destination early. If an unrelated instruction reads that register before the strand's last member arrives, the engine emits a load of the saved older value. The last member is then turned back into a strand write, so the final result still lands in program order.

A kill input, such as a branch mispredict, discards the strand that is in flight and all dirty marks. Each accepted input produces its output one cycle later. The engine tracks one strand at a time.

Top module: `strand_dispatch`

## Requirements
- R1: While reset is asserted and right after it is released, `out_valid` is 0 and `in_ready` is 1. No register is marked dirty after reset.
- R2: A valid input whose PC hits a strand that is ready, has a length from 2 to MAX_LEN, and arrives while no strand is outstanding produces, one cycle later, an output of kind 1 (strand). That output carries the head PC, `out_wr`=1, the last member's destination in `out_dst` and the last member's result in `out_val`. A hit that is not ready passes through as a normal instruction.
- R3: While a strand is outstanding, an input whose PC equals one of its members that has not yet arrived produces no output. This holds for the last member too, unless R5 or R10 applies.
- R4: An input that reads a dirty register produces a recovery output of kind 2 before the reader. It carries `out_dst` = that register, `out_val` = the saved result and `out_wr`=1. When both sources are dirty, the first source is recovered before the second.
- R5: While a strand is outstanding, a non-member input that reads the strand's final destination, and whose sources are not dirty, produces an output of kind 3 (load-immediate) carrying the saved older value. When the last member arrives later, it produces a kind 1 output with the strand's final result.
- R6: `in_ready` is 0 in each cycle in which a recovery or load-immediate is inserted, and 1 whenever `in_valid` is 0. The held reader is output as a normal instruction once no fix-up remains.
- R7: A dirty mark is cleared when the register is recovered or written by a normal instruction. A later read then passes with no fix-up.
- R8: While `kill` is high, no output is produced in the next cycle. Kill also cancels the outstanding strand and all dirty marks.
- R9: Any other valid input is output one cycle later with kind 0 (normal): the same PC, destination, write flag and sources, and `out_val`=0.
- R10: A normal instruction that writes the final destination of an outstanding strand disables the load-immediate for that strand. It also makes the strand's last member produce a kind 1 output with the strand's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| kill | input | 1 | Squash: drops the current input, the outstanding strand and all dirty marks |
| in_valid | input | 1 | Decoded instruction present |
| in_pc | input | PC_W | Instruction PC |
| in_wr | input | 1 | Instruction writes `in_dst` |
| in_dst | input | log2(REG_N) | Destination register |
| in_src1 | input | log2(REG_N) | First source register |
| in_src2 | input | log2(REG_N) | Second source register |
| in_ready | output | 1 | Input accepted this cycle; low while a fix-up is inserted |
| lk_pc | output | PC_W | Strand store lookup address |
| lk_hit | input | 1 | Lookup address is the head of a stored strand |
| lk_ready | input | 1 | Stored strand has its result |
| lk_len | input | log2(MAX_LEN+1) | Member count |
| lk_mpc | input | MAX_LEN*PC_W | Member PCs, slot 0 in the low bits, slot 0 is the head |
| lk_mdst | input | MAX_LEN*log2(REG_N) | Member destination registers |
| lk_mval | input | MAX_LEN*DATA_W | Member results |
| lk_prev | input | DATA_W | Older value of the final destination |
| out_valid | output | 1 | Output instruction present |
| out_kind | output | 2 | 0 normal, 1 strand, 2 recovery, 3 load-immediate |
| out_pc | output | PC_W | PC of the instruction that caused the output |
| out_dst | output | log2(REG_N) | Destination register |
| out_wr | output | 1 | Output writes `out_dst` |
| out_src1 | output | log2(REG_N) | First source (0 for inserted kinds) |
| out_src2 | output | log2(REG_N) | Second source (0 for inserted kinds) |
| out_val | output | DATA_W | Immediate value for kinds 1 to 3, else 0 |

## Verification
Every output is registered once, so the result of an input driven before edge k is due just after edge k. The bench samples it one time unit after that edge. `in_ready` is combinational and is sampled before the edge at which the input is presented. A reader held by a fix-up is checked again at each following edge until its normal output appears: one extra edge per recovery or load-immediate. Kill is checked at the edge it is high on, and its effect on later strand members and dirty reads is checked at the edges that follow.

// File: rtl/sd_pkg.sv
package sd_pkg;
   typedef enum logic [1:0] {
      K_NORM   = 2'd0,
      K_STRAND = 2'd1,
      K_RECOV  = 2'd2,
      K_LDIMM  = 2'd3
   } kind_e;
endpackage

// File: rtl/sd_dirty_table.sv
module sd_dirty_table #(
   parameter int REG_N  = 32,
   parameter int REG_W  = 5,
   parameter int DATA_W = 16,
   parameter int SET_N  = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    flush,
   input  logic [SET_N-1:0]        set_en,
   input  logic [SET_N*REG_W-1:0]  set_reg,
   input  logic [SET_N*DATA_W-1:0] set_val,
   input  logic                    clr_en,
   input  logic [REG_W-1:0]        clr_reg,
   input  logic [REG_W-1:0]        qa_reg,
   input  logic [REG_W-1:0]        qb_reg,
   output logic                    qa_dirty,
   output logic [DATA_W-1:0]       qa_val,
   output logic                    qb_dirty,
   output logic [DATA_W-1:0]       qb_val
);
   logic [REG_N-1:0]  dirty_q;
   logic [DATA_W-1:0] val_q [REG_N];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dirty_q <= '0;
         for (int r = 0; r < REG_N; r++) val_q[r] <= '0;
      end else if (flush) begin
         dirty_q <= '0;
      end else begin
         if (clr_en) dirty_q[clr_reg] <= 1'b0;
         for (int s = 0; s < SET_N; s++) begin
            if (set_en[s]) begin
               dirty_q[set_reg[s*REG_W +: REG_W]] <= 1'b1;
               val_q[set_reg[s*REG_W +: REG_W]]   <= set_val[s*DATA_W +: DATA_W];
            end
         end
      end
   end

   assign qa_dirty = dirty_q[qa_reg];
   assign qb_dirty = dirty_q[qb_reg];
   assign qa_val   = val_q[qa_reg];
   assign qb_val   = val_q[qb_reg];
endmodule

// File: rtl/sd_member_track.sv
module sd_member_track #(
   parameter int PC_W    = 16,
   parameter int REG_W   = 5,
   parameter int DATA_W  = 16,
   parameter int MAX_LEN = 3,
   parameter int LEN_W   = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      kill,
   input  logic                      load,
   input  logic [LEN_W-1:0]          ld_len,
   input  logic [MAX_LEN*PC_W-1:0]   ld_pc,
   input  logic [REG_W-1:0]          ld_fdst,
   input  logic [DATA_W-1:0]         ld_fval,
   input  logic [DATA_W-1:0]         ld_prev,
   input  logic [PC_W-1:0]           q_pc,
   input  logic                      consume,
   input  logic                      set_refire,
   output logic                      pending,
   output logic                      hit,
   output logic                      hit_final,
   output logic                      win_open,
   output logic                      refire,
   output logic [REG_W-1:0]          fdst,
   output logic [DATA_W-1:0]         fval,
   output logic [DATA_W-1:0]         prev
);
   logic [MAX_LEN-1:0] slot_v;
   logic [PC_W-1:0]    slot_pc [MAX_LEN];
   logic [LEN_W-1:0]   fin_idx;
   logic [MAX_LEN-1:0] match;
   logic [MAX_LEN-1:0] fin_oh;
   logic               win_q, refire_q;

   for (genvar i = 0; i < MAX_LEN; i++) begin : g_slot
      assign match[i]  = slot_v[i] && (slot_pc[i] == q_pc);
      assign fin_oh[i] = (fin_idx == LEN_W'(i));
   end

   assign pending   = |slot_v;
   assign hit       = |match;
   assign hit_final = |(match & fin_oh);
   assign win_open  = win_q;
   assign refire    = refire_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_v   <= '0;
         fin_idx  <= '0;
         win_q    <= 1'b0;
         refire_q <= 1'b0;
         fdst     <= '0;
         fval     <= '0;
         prev     <= '0;
         for (int i = 0; i < MAX_LEN; i++) slot_pc[i] <= '0;
      end else if (kill) begin
         slot_v   <= '0;
         win_q    <= 1'b0;
         refire_q <= 1'b0;
      end else if (load) begin
         for (int i = 0; i < MAX_LEN; i++) begin
            slot_v[i]  <= (i != 0) && (LEN_W'(i) < ld_len);
            slot_pc[i] <= ld_pc[i*PC_W +: PC_W];
         end
         fin_idx  <= ld_len - LEN_W'(1);
         fdst     <= ld_fdst;
         fval     <= ld_fval;
         prev     <= ld_prev;
         win_q    <= 1'b1;
         refire_q <= 1'b0;
      end else if (consume) begin
         if (hit_final) begin
            slot_v   <= '0;
            win_q    <= 1'b0;
            refire_q <= 1'b0;
         end else begin
            slot_v <= slot_v & ~match;
         end
      end else if (set_refire) begin
         refire_q <= 1'b1;
         win_q    <= 1'b0;
      end
   end
endmodule

// File: rtl/strand_dispatch.sv
module strand_dispatch #(
   parameter int PC_W    = 16,
   parameter int REG_N   = 32,
   parameter int DATA_W  = 16,
   parameter int MAX_LEN = 3,
   localparam int REG_W  = $clog2(REG_N),
   localparam int LEN_W  = $clog2(MAX_LEN + 1)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      kill,
   input  logic                      in_valid,
   input  logic [PC_W-1:0]           in_pc,
   input  logic                      in_wr,
   input  logic [REG_W-1:0]          in_dst,
   input  logic [REG_W-1:0]          in_src1,
   input  logic [REG_W-1:0]          in_src2,
   output logic                      in_ready,
   output logic [PC_W-1:0]           lk_pc,
   input  logic                      lk_hit,
   input  logic                      lk_ready,
   input  logic [LEN_W-1:0]          lk_len,
   input  logic [MAX_LEN*PC_W-1:0]   lk_mpc,
   input  logic [MAX_LEN*REG_W-1:0]  lk_mdst,
   input  logic [MAX_LEN*DATA_W-1:0] lk_mval,
   input  logic [DATA_W-1:0]         lk_prev,
   output logic                      out_valid,
   output logic [1:0]                out_kind,
   output logic [PC_W-1:0]           out_pc,
   output logic [REG_W-1:0]          out_dst,
   output logic                      out_wr,
   output logic [REG_W-1:0]          out_src1,
   output logic [REG_W-1:0]          out_src2,
   output logic [DATA_W-1:0]         out_val
);
   import sd_pkg::*;

   localparam int SET_N = MAX_LEN - 1;

   if (MAX_LEN < 2) begin : g_bad_len
      $error("strand_dispatch: MAX_LEN must be at least 2");
   end
   if (REG_N < 2 || (1 << REG_W) != REG_N) begin : g_bad_regs
      $error("strand_dispatch: REG_N must be a power of two");
   end
   if (PC_W < 2 || DATA_W < 1) begin : g_bad_width
      $error("strand_dispatch: bad PC_W or DATA_W");
   end

   // dirty table and member tracker hookups
   logic                    qa_dirty, qb_dirty;
   logic [DATA_W-1:0]       qa_val, qb_val;
   logic [SET_N-1:0]        set_en;
   logic                    clr_en;
   logic [REG_W-1:0]        clr_reg;
   logic                    trk_pending, trk_hit, trk_hit_final;
   logic                    trk_win, trk_refire, trk_set_refire;
   logic [REG_W-1:0]        trk_fdst;
   logic [DATA_W-1:0]       trk_fval, trk_prev;

   // lookup decode
   logic                    strand_ok;
   logic [REG_W-1:0]        lk_fdst;
   logic [DATA_W-1:0]       lk_fval;

   // decisions
   logic act, rd_final;
   logic do_member, do_rec_a, do_rec_b, do_ldimm, do_inject, do_pass;

   assign lk_pc = in_pc;

   assign strand_ok = lk_hit && lk_ready &&
                      (lk_len >= LEN_W'(2)) && ({1'b0, lk_len} <= (LEN_W+1)'(MAX_LEN));

   always_comb begin
      lk_fdst = '0;
      lk_fval = '0;
      for (int s = 0; s < MAX_LEN; s++) begin
         if (lk_len == LEN_W'(s + 1)) begin
            lk_fdst = lk_mdst[s*REG_W +: REG_W];
            lk_fval = lk_mval[s*DATA_W +: DATA_W];
         end
      end
   end

   for (genvar s = 0; s < SET_N; s++) begin : g_set
      assign set_en[s] = do_inject && (LEN_W'(s + 1) < lk_len);
   end

   assign act       = in_valid && !kill;
   assign rd_final  = trk_win && ((in_src1 == trk_fdst) || (in_src2 == trk_fdst));
   assign do_member = act && trk_hit;
   assign do_rec_a  = act && !trk_hit && qa_dirty;
   assign do_rec_b  = act && !trk_hit && !qa_dirty && qb_dirty;
   assign do_ldimm  = act && !trk_hit && !qa_dirty && !qb_dirty && rd_final;
   assign do_inject = act && !trk_hit && !qa_dirty && !qb_dirty && !rd_final &&
                      !trk_pending && strand_ok;
   assign do_pass   = act && !trk_hit && !qa_dirty && !qb_dirty && !rd_final && !do_inject;

   assign in_ready = !(do_rec_a || do_rec_b || do_ldimm);

   assign clr_en  = do_rec_a || do_rec_b || (do_pass && in_wr);
   assign clr_reg = do_rec_a ? in_src1 : (do_rec_b ? in_src2 : in_dst);

   assign trk_set_refire = do_ldimm ||
                           (do_pass && in_wr && trk_pending && (in_dst == trk_fdst));

   sd_dirty_table #(
      .REG_N (REG_N),
      .REG_W (REG_W),
      .DATA_W(DATA_W),
      .SET_N (SET_N)
   ) u_dirty (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush   (kill),
      .set_en  (set_en),
      .set_reg (lk_mdst[SET_N*REG_W-1:0]),
      .set_val (lk_mval[SET_N*DATA_W-1:0]),
      .clr_en  (clr_en),
      .clr_reg (clr_reg),
      .qa_reg  (in_src1),
      .qb_reg  (in_src2),
      .qa_dirty(qa_dirty),
      .qa_val  (qa_val),
      .qb_dirty(qb_dirty),
      .qb_val  (qb_val)
   );

   sd_member_track #(
      .PC_W   (PC_W),
      .REG_W  (REG_W),
      .DATA_W (DATA_W),
      .MAX_LEN(MAX_LEN),
      .LEN_W  (LEN_W)
   ) u_track (
      .clk       (clk),
      .rst_n     (rst_n),
      .kill      (kill),
      .load      (do_inject),
      .ld_len    (lk_len),
      .ld_pc     (lk_mpc),
      .ld_fdst   (lk_fdst),
      .ld_fval   (lk_fval),
      .ld_prev   (lk_prev),
      .q_pc      (in_pc),
      .consume   (do_member),
      .set_refire(trk_set_refire),
      .pending   (trk_pending),
      .hit       (trk_hit),
      .hit_final (trk_hit_final),
      .win_open  (trk_win),
      .refire    (trk_refire),
      .fdst      (trk_fdst),
      .fval      (trk_fval),
      .prev      (trk_prev)
   );

   // output stage
   logic              n_v, n_wr;
   kind_e             n_kind, kind_q;
   logic [PC_W-1:0]   n_pc;
   logic [REG_W-1:0]  n_dst, n_s1, n_s2;
   logic [DATA_W-1:0] n_val;

   always_comb begin
      n_v    = 1'b0;
      n_kind = K_NORM;
      n_pc   = in_pc;
      n_dst  = '0;
      n_wr   = 1'b0;
      n_s1   = '0;
      n_s2   = '0;
      n_val  = '0;
      if (do_inject) begin
         n_v    = 1'b1;
         n_kind = K_STRAND;
         n_dst  = lk_fdst;
         n_wr   = 1'b1;
         n_val  = lk_fval;
      end else if (do_member && trk_hit_final && trk_refire) begin
         n_v    = 1'b1;
         n_kind = K_STRAND;
         n_dst  = trk_fdst;
         n_wr   = 1'b1;
         n_val  = trk_fval;
      end else if (do_rec_a) begin
         n_v    = 1'b1;
         n_kind = K_RECOV;
         n_dst  = in_src1;
         n_wr   = 1'b1;
         n_val  = qa_val;
      end else if (do_rec_b) begin
         n_v    = 1'b1;
         n_kind = K_RECOV;
         n_dst  = in_src2;
         n_wr   = 1'b1;
         n_val  = qb_val;
      end else if (do_ldimm) begin
         n_v    = 1'b1;
         n_kind = K_LDIMM;
         n_dst  = trk_fdst;
         n_wr   = 1'b1;
         n_val  = trk_prev;
      end else if (do_pass) begin
         n_v    = 1'b1;
         n_dst  = in_dst;
         n_wr   = in_wr;
         n_s1   = in_src1;
         n_s2   = in_src2;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         kind_q    <= K_NORM;
         out_pc    <= '0;
         out_dst   <= '0;
         out_wr    <= 1'b0;
         out_src1  <= '0;
         out_src2  <= '0;
         out_val   <= '0;
      end else begin
         out_valid <= n_v;
         kind_q    <= n_kind;
         out_pc    <= n_pc;
         out_dst   <= n_dst;
         out_wr    <= n_wr;
         out_src1  <= n_s1;
         out_src2  <= n_s2;
         out_val   <= n_val;
      end
   end

   assign out_kind = kind_q;
endmodule

// File: rtl/sd_checker.sv
module sd_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       kill,
   input logic       in_valid,
   input logic       in_ready,
   input logic       lk_hit,
   input logic       pending,
   input logic       out_valid,
   input logic [1:0] out_kind,
   input logic       out_wr,
   input logic [3:0] out_val_nz
);
   AST_KILL_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
      kill |=> !out_valid); // R8
   AST_STALL_FIXUP: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_ready && !kill) |=> (out_valid && (out_kind == 2'd2 || out_kind == 2'd3))); // R6
   AST_IDLE_READY: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |-> in_ready); // R6
   AST_FIXUP_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_kind != 2'd0) |-> out_wr); // R4
   AST_PASS_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && !kill && !pending && !lk_hit) |=> (out_valid && out_kind == 2'd0)); // R9
   AST_NORMAL_NO_IMM: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_kind == 2'd0) |-> (out_val_nz == 4'd0)); // R9
endmodule

bind strand_dispatch sd_checker u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .kill      (kill),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .lk_hit    (lk_hit),
   .pending   (trk_pending),
   .out_valid (out_valid),
   .out_kind  (out_kind),
   .out_wr    (out_wr),
   .out_val_nz({3'd0, |out_val})
);

// File: tb/strand_dispatch_test.sv
`timescale 1ns/1ps
module strand_dispatch_test;
   localparam int PC_W = 16, REG_W = 5, DATA_W = 16, MAX_LEN = 3, LEN_W = 2;

   logic clk = 1'b0, rst_n = 1'b0, kill = 1'b0;
   logic in_valid = 1'b0, in_wr = 1'b0, in_ready;
   logic [PC_W-1:0] in_pc = '0, lk_pc;
   logic [REG_W-1:0] in_dst = '0, in_src1 = '0, in_src2 = '0;
   logic lk_hit, lk_ready;
   logic [LEN_W-1:0] lk_len;
   logic [MAX_LEN*PC_W-1:0] lk_mpc;
   logic [MAX_LEN*REG_W-1:0] lk_mdst;
   logic [MAX_LEN*DATA_W-1:0] lk_mval;
   logic [DATA_W-1:0] lk_prev;
   logic out_valid, out_wr;
   logic [1:0] out_kind;
   logic [PC_W-1:0] out_pc;
   logic [REG_W-1:0] out_dst, out_src1, out_src2;
   logic [DATA_W-1:0] out_val;

   bit st_en = 1'b1, st_rdy = 1'b1, done = 1'b0;
   int n_run = 0, n_fail = 0;

   always #4 clk = ~clk;

   // strand store model: head 0x100, members 0x108, 0x110; dst r5, r6, r7
   always_comb begin
      lk_hit   = st_en && (lk_pc == 16'h0100);
      lk_ready = st_rdy;
      lk_len   = 2'd3;
      lk_mpc   = {16'h0110, 16'h0108, 16'h0100};
      lk_mdst  = {5'd7, 5'd6, 5'd5};
      lk_mval  = {16'd33, 16'd22, 16'd11};
      lk_prev  = 16'd77;
   end

   strand_dispatch uut (
      .clk(clk), .rst_n(rst_n), .kill(kill), .in_valid(in_valid), .in_pc(in_pc),
      .in_wr(in_wr), .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2),
      .in_ready(in_ready), .lk_pc(lk_pc), .lk_hit(lk_hit), .lk_ready(lk_ready),
      .lk_len(lk_len), .lk_mpc(lk_mpc), .lk_mdst(lk_mdst), .lk_mval(lk_mval),
      .lk_prev(lk_prev), .out_valid(out_valid), .out_kind(out_kind), .out_pc(out_pc),
      .out_dst(out_dst), .out_wr(out_wr), .out_src1(out_src1), .out_src2(out_src2),
      .out_val(out_val)
   );

   function automatic logic [49:0] mk(input logic [1:0] k, input logic [15:0] pc,
      input logic [4:0] d, input logic w, input logic [4:0] a, input logic [4:0] b,
      input logic [15:0] v);
      return {k, pc, d, w, a, b, v};
   endfunction
   function automatic logic [49:0] norm(input logic [15:0] pc, input logic w,
      input logic [4:0] d, input logic [4:0] a, input logic [4:0] b);
      return mk(2'd0, pc, d, w, a, b, 16'd0);
   endfunction
   function automatic logic [49:0] fix(input logic [1:0] k, input logic [15:0] pc,
      input logic [4:0] d, input logic [15:0] v);
      return mk(k, pc, d, 1'b1, 5'd0, 5'd0, v);
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic put(input logic [15:0] pc, input logic w, input logic [4:0] d,
      input logic [4:0] a, input logic [4:0] b, input logic k);
      @(negedge clk);
      in_valid = 1'b1; in_pc = pc; in_wr = w; in_dst = d; in_src1 = a; in_src2 = b; kill = k;
   endtask

   task automatic idle(input logic k);
      @(negedge clk);
      in_valid = 1'b0; kill = k;
   endtask

   task automatic step(input bit exp_rdy, input bit exp_v, input logic [49:0] exp, input string tag);
      logic [49:0] got;
      #1;
      chk(in_ready == exp_rdy, {tag, " ready"}, 64'(in_ready), 64'(exp_rdy));
      @(posedge clk);
      #1;
      got = {out_kind, out_pc, out_dst, out_wr, out_src1, out_src2, out_val};
      chk(out_valid == exp_v, {tag, " valid"}, 64'(out_valid), 64'(exp_v));
      if (exp_v) chk(got == exp, {tag, " fields"}, 64'(got), 64'(exp));
   endtask

   task automatic pulse_kill();
      idle(1'b1);
      step(1'b1, 1'b0, '0, "R8 kill idle");
      idle(1'b0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      if (!done) $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      #1;
      chk(out_valid == 1'b0, "R1 out_valid in reset", 64'(out_valid), 64'd0);
      chk(in_ready == 1'b1, "R1 in_ready in reset", 64'(in_ready), 64'd1);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk(out_valid == 1'b0, "R1 out_valid after reset", 64'(out_valid), 64'd0);
      put(16'h0200, 1'b1, 5'd9, 5'd5, 5'd6, 1'b0);
      step(1'b1, 1'b1, norm(16'h0200, 1'b1, 5'd9, 5'd5, 5'd6), "R1 no dirty after reset");

      // scenario A: inject, delete, recover, load-immediate, refire
      put(16'h0100, 1'b1, 5'd5, 5'd1, 5'd2, 1'b0);
      step(1'b1, 1'b1, fix(2'd1, 16'h0100, 5'd7, 16'd33), "R2 inject");
      put(16'h0104, 1'b1, 5'd9, 5'd1, 5'd2, 1'b0);
      step(1'b1, 1'b1, norm(16'h0104, 1'b1, 5'd9, 5'd1, 5'd2), "R9 pass");
      put(16'h0108, 1'b1, 5'd6, 5'd5, 5'd3, 1'b0);
      step(1'b1, 1'b0, '0, "R3 member removed");
      put(16'h010C, 1'b1, 5'd10, 5'd5, 5'd4, 1'b0);
      step(1'b0, 1'b1, fix(2'd2, 16'h010C, 5'd5, 16'd11), "R4 recover src1");
      step(1'b1, 1'b1, norm(16'h010C, 1'b1, 5'd10, 5'd5, 5'd4), "R6 reader after recover");
      put(16'h01F0, 1'b1, 5'd11, 5'd3, 5'd7, 1'b0);
      step(1'b0, 1'b1, fix(2'd3, 16'h01F0, 5'd7, 16'd77), "R5 load-immediate");
      step(1'b1, 1'b1, norm(16'h01F0, 1'b1, 5'd11, 5'd3, 5'd7), "R6 reader after ldimm");
      put(16'h0110, 1'b1, 5'd7, 5'd6, 5'd1, 1'b0);
      step(1'b1, 1'b1, fix(2'd1, 16'h0110, 5'd7, 16'd33), "R5 final refire");
      put(16'h0114, 1'b1, 5'd12, 5'd5, 5'd0, 1'b0);
      step(1'b1, 1'b1, norm(16'h0114, 1'b1, 5'd12, 5'd5, 5'd0), "R7 recovered reg clean");
      put(16'h0118, 1'b0, 5'd0, 5'd2, 5'd6, 1'b0);
      step(1'b0, 1'b1, fix(2'd2, 16'h0118, 5'd6, 16'd22), "R4 recover src2");
      step(1'b1, 1'b1, norm(16'h0118, 1'b0, 5'd0, 5'd2, 5'd6), "R6 reader after src2");
      pulse_kill();

      // scenario B: normal writes clear dirty and force refire
      put(16'h0100, 1'b1, 5'd5, 5'd1, 5'd2, 1'b0);
      step(1'b1, 1'b1, fix(2'd1, 16'h0100, 5'd7, 16'd33), "R2 inject again");
      put(16'h0140, 1'b1, 5'd5, 5'd1, 5'd2, 1'b0);
      step(1'b1, 1'b1, norm(16'h0140, 1'b1, 5'd5, 5'd1, 5'd2), "R7 normal write");
      put(16'h0144, 1'b1, 5'd7, 5'd1, 5'd2, 1'b0);
      step(1'b1, 1'b1, norm(16'h0144, 1'b1, 5'd7, 5'd1, 5'd2), "R10 write final dst");
      put(16'h0148, 1'b0, 5'd0, 5'd5, 5'd7, 1'b0);
      step(1'b1, 1'b1, norm(16'h0148, 1'b0, 5'd0, 5'd5, 5'd7), "R10 no ldimm R7 clean");
      put(16'h0108, 1'b1, 5'd6, 5'd5, 5'd3, 1'b0);
      step(1'b1, 1'b0, '0, "R3 middle removed");
      put(16'h0110, 1'b1, 5'd7, 5'd6, 5'd1, 1'b0);
      step(1'b1, 1'b1, fix(2'd1, 16'h0110, 5'd7, 16'd33), "R10 final refire");
      pulse_kill();

      // scenario C: two dirty sources, plain final removal, kill with input
      put(16'h0100, 1'b1, 5'd5, 5'd1, 5'd2, 1'b0);
      step(1'b1, 1'b1, fix(2'd1, 16'h0100, 5'd7, 16'd33), "R2 inject third");
      put(16'h0150, 1'b1, 5'd13, 5'd6, 5'd5, 1'b0);
      step(1'b0, 1'b1, fix(2'd2, 16'h0150, 5'd6, 16'd22), "R4 both dirty first");
      step(1'b0, 1'b1, fix(2'd2, 16'h0150, 5'd5, 16'd11), "R4 both dirty second");
      step(1'b1, 1'b1, norm(16'h0150, 1'b1, 5'd13, 5'd6, 5'd5), "R6 after two fixups");
      put(16'h0108, 1'b1, 5'd6, 5'd5, 5'd3, 1'b0);
      step(1'b1, 1'b0, '0, "R3 middle removed");
      put(16'h0110, 1'b1, 5'd7, 5'd6, 5'd1, 1'b0);
      step(1'b1, 1'b0, '0, "R3 final removed");
      put(16'h0100, 1'b1, 5'd5, 5'd1, 5'd2, 1'b0);
      step(1'b1, 1'b1, fix(2'd1, 16'h0100, 5'd7, 16'd33), "R2 rearmed");
      put(16'h0108, 1'b1, 5'd6, 5'd5, 5'd3, 1'b1);
      step(1'b1, 1'b0, '0, "R8 kill with input");
      put(16'h0108, 1'b1, 5'd6, 5'd5, 5'd3, 1'b0);
      step(1'b1, 1'b1, norm(16'h0108, 1'b1, 5'd6, 5'd5, 5'd3), "R8 member no longer removed");
      put(16'h0160, 1'b0, 5'd0, 5'd6, 5'd7, 1'b0);
      step(1'b1, 1'b1, norm(16'h0160, 1'b0, 5'd0, 5'd6, 5'd7), "R8 dirty flushed");

      // scenario D: strand not ready
      st_rdy = 1'b0;
      put(16'h0100, 1'b1, 5'd5, 5'd1, 5'd2, 1'b0);
      step(1'b1, 1'b1, norm(16'h0100, 1'b1, 5'd5, 5'd1, 5'd2), "R2 not ready passes");
      put(16'h0108, 1'b1, 5'd6, 5'd5, 5'd3, 1'b0);
      step(1'b1, 1'b1, norm(16'h0108, 1'b1, 5'd6, 5'd5, 5'd3), "R2 no strand outstanding");
      st_rdy = 1'b1;
      pulse_kill();

      // random pass-through traffic
      for (int i = 0; i < 300; i++) begin
         logic [15:0] pc;
         logic [4:0]  d, a, b;
         logic        w;
         pc = 16'h2000 | 16'($urandom_range(0, 16'h0FFF));
         d  = 5'($urandom); a = 5'($urandom); b = 5'($urandom); w = 1'($urandom);
         if ($urandom_range(0, 4) == 0) begin
            idle(1'b0);
            step(1'b1, 1'b0, '0, "R6 R9 idle cycle");
         end else begin
            put(pc, w, d, a, b, 1'b0);
            step(1'b1, 1'b1, norm(pc, w, d, a, b), "R9 random pass");
         end
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule